// File: doc/BRIEF.md
# Pulse-and-Verify Byte Programming Sequencer

This block writes a range of bytes into an erasable programmable memory device. It uses the fast programming method. Each byte gets a series of short programming pulses, and each pulse is followed by a read-back check. Once the byte reads back correctly, one longer pulse follows to give it margin, and that pulse's length is proportional to the number of short pulses the byte needed. Software or a host block supplies a first and a last address and then pulses `start`. The sequencer asks for each source byte through a request channel and takes the byte from a response channel. It then drives the device address, the data bus, the active-low chip and output strobes, and the enable for the high programming supply.

All intervals come from one down-counter, which counts ticks of a clock prescaler. `CLKS_PER_TICK` sets how many clocks make one tick. `TICKS_PER_MS` sets how many ticks make one millisecond of pulse time. The run ends in one of two ways: `done` rises after the last byte, or `fail` rises with the failing address on `fail_addr` when a byte does not verify within `MAX_TRIES` short pulses.

Both source channels use valid/ready handshakes. A transfer happens on a rising clock edge where valid and ready are both high. A request (`fetch_valid`, `fetch_addr`) stays asserted with a stable address until `fetch_ready` accepts it. The sequencer has at most one request outstanding. It raises `src_ready` only while it waits for that single response, so the source may hold `src_valid` for any number of cycles.

Top module: `burn_sequencer`

## Requirements
- R1: After reset, `dev_e_n` and `dev_g_n` are high, and `vpp_en`, `busy`, `done`, `fail`, `fetch_valid` and `dev_drive` are low.
- R2: `fetch_valid` with `fetch_addr` stays asserted and stable until `fetch_ready`. The source byte is taken only on a cycle where `src_valid` and `src_ready` are both high.
- R3: Each short programming pulse holds `dev_e_n` low for exactly `TICKS_PER_MS` ticks (`TICKS_PER_MS*CLKS_PER_TICK` clocks). During the pulse `dev_g_n` is high, `dev_drive` is high and the byte is on `dev_wdata`.
- R4: After every short pulse there is one verify window of one tick. In it, `dev_e_n` and `dev_g_n` are both low and `dev_drive` is low, and `dev_rdata` is compared with the source byte at the end of the window.
- R5: Short pulses repeat until a verify matches. A byte that needs k short pulses receives exactly k+1 pulses in total.
- R6: After a match, one overprogram pulse holds `dev_e_n` low for 3*n*`TICKS_PER_MS` ticks, where n is the number of short pulses the byte took. No verify follows it.
- R7: If the verify after short pulse number `MAX_TRIES` still mismatches, the run stops: `fail` is high, `fail_addr` holds the byte's address, `done` is low, and no further pulses or later addresses follow.
- R8: `dev_addr` and `dev_wdata` change at least one tick before `dev_e_n` falls and at least one tick after it rises, and never while `dev_e_n` is low. `dev_g_n` falls at least one tick after a programming pulse ends.
- R9: Addresses are programmed in ascending order from `first_addr` to `last_addr` inclusive. `done` rises after the last byte, and addresses outside the range receive no pulses.
- R10: A source byte with all bits set (FFh) gets no pulse and no verify, and the sequencer moves on to the next address.
- R11: `vpp_en` is high from the cycle after `start` is accepted until the run ends, and it covers every pulse. At the end `vpp_en` and `busy` are low and both strobes are high.
- R12: `start` while `busy` is ignored. The ongoing run keeps its range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled only while idle) |
| first_addr | input | ADDR_W | First address of the range |
| last_addr | input | ADDR_W | Last address of the range, inclusive |
| fetch_valid | output | 1 | Source byte request valid |
| fetch_ready | input | 1 | Source accepts the request |
| fetch_addr | output | ADDR_W | Address of the requested byte |
| src_valid | input | 1 | Source byte valid |
| src_ready | output | 1 | Sequencer takes the source byte |
| src_data | input | DATA_W | Source byte |
| dev_addr | output | ADDR_W | Device address |
| dev_wdata | output | DATA_W | Data presented to the device |
| dev_drive | output | 1 | Data bus output enable toward the device |
| dev_rdata | input | DATA_W | Data read from the device |
| dev_e_n | output | 1 | Device chip strobe, active low |
| dev_g_n | output | 1 | Device output strobe, active low |
| vpp_en | output | 1 | Programming supply enable |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished without failure |
| fail | output | 1 | Last run stopped on a byte that would not verify |
| fail_addr | output | ADDR_W | Address of the failing byte |

## Verification
A wrong pulse count or a wrong try counter shows up at the ports no later than the end of the affected byte. It appears as one pulse too many or too few, or as an overprogram strobe whose width is not three times the number of short pulses. A wrong timer reload shows on the very next strobe as a width that is off by whole ticks, so every strobe edge is timed in clocks. A wrong address register or range compare shows up by the end of the run, as pulses recorded at addresses outside the range or as a misplaced `fail_addr`. A misplaced bus-drive decode shows in the same cycle as a verify window with the data bus still driven.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_REQ    = 3'd1,
    S_WAIT   = 3'd2,
    S_SETUP  = 3'd3,
    S_PULSE  = 3'd4,
    S_RECOV  = 3'd5,
    S_VERIFY = 3'd6,
    S_NEXT   = 3'd7
  } seq_state_t;
endpackage

// File: rtl/fpa_timer.sv
module fpa_timer #(
  parameter int CLKS_PER_TICK = 50,
  parameter int TW            = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          fire
);
  logic          tick;
  logic [TW-1:0] cnt;

  generate
    if (CLKS_PER_TICK <= 1) begin : g_notick
      assign tick = 1'b1;
    end else begin : g_pre
      localparam int PW = $clog2(CLKS_PER_TICK);
      logic [PW-1:0] pre;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        pre <= '0;
        else if (load)                     pre <= '0;
        else if (pre == PW'(CLKS_PER_TICK - 1)) pre <= '0;
        else                               pre <= pre + 1'b1;
      end
      assign tick = (pre == PW'(CLKS_PER_TICK - 1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign fire = tick && (cnt == TW'(1));

  assert_cnt_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/fpa_ctrl.sv
module fpa_ctrl
  import fpa_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 8,
  parameter int TICKS_PER_MS = 1000,
  parameter int MAX_TRIES    = 25,
  parameter int TW           = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] last_addr,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  input  logic [DATA_W-1:0] dev_rdata,
  input  logic              fire,
  output logic              load,
  output logic [TW-1:0]     load_val,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [DATA_W-1:0] dev_wdata,
  output logic              dev_drive,
  output logic              dev_e_n,
  output logic              dev_g_n,
  output logic              vpp_en,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam int          NW       = $clog2(MAX_TRIES + 1);
  localparam logic [TW-1:0] MS_T   = TW'(TICKS_PER_MS);
  localparam logic [TW-1:0] OVR_U  = TW'(3 * TICKS_PER_MS);
  localparam logic [TW-1:0] GAP_T  = TW'(1);
  localparam logic [NW-1:0] N_MAX  = NW'(MAX_TRIES);

  seq_state_t        state, nxt;
  logic [ADDR_W-1:0] addr_q, last_q;
  logic [DATA_W-1:0] data_q;
  logic [NW-1:0]     tries;
  logic              over_q;
  logic              match, at_last;
  logic [TW-1:0]     over_len;

  assign match    = (dev_rdata == data_q);
  assign at_last  = (addr_q == last_q);
  assign over_len = TW'(tries) * OVR_U;

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = GAP_T;
    case (state)
      S_IDLE:  if (start) nxt = S_REQ;
      S_REQ:   if (fetch_ready) nxt = S_WAIT;
      S_WAIT:  if (src_valid) begin
                 if (src_data == {DATA_W{1'b1}}) nxt = S_NEXT;
                 else begin nxt = S_SETUP; load = 1'b1; end
               end
      S_SETUP: if (fire) begin
                 nxt = S_PULSE; load = 1'b1;
                 load_val = over_q ? over_len : MS_T;
               end
      S_PULSE: if (fire) begin nxt = S_RECOV; load = 1'b1; end
      S_RECOV: if (fire) begin
                 if (over_q) nxt = S_NEXT;
                 else begin nxt = S_VERIFY; load = 1'b1; end
               end
      S_VERIFY: if (fire) begin
                 if (match || tries != N_MAX) begin nxt = S_SETUP; load = 1'b1; end
                 else nxt = S_IDLE;
               end
      S_NEXT:  nxt = at_last ? S_IDLE : S_REQ;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      addr_q    <= '0;
      last_q    <= '0;
      data_q    <= '0;
      tries     <= '0;
      over_q    <= 1'b0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
    end else begin
      state <= nxt;
      case (state)
        S_IDLE: if (start) begin
          addr_q <= first_addr;
          last_q <= last_addr;
          done   <= 1'b0;
          fail   <= 1'b0;
        end
        S_WAIT: if (src_valid) begin
          data_q <= src_data;
          tries  <= '0;
          over_q <= 1'b0;
        end
        S_SETUP: if (fire && !over_q) tries <= tries + 1'b1;
        S_VERIFY: if (fire) begin
          if (match) over_q <= 1'b1;
          else if (tries == N_MAX) begin
            fail      <= 1'b1;
            fail_addr <= addr_q;
          end
        end
        S_NEXT: begin
          if (at_last) done <= 1'b1;
          else         addr_q <= addr_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign fetch_valid = (state == S_REQ);
  assign fetch_addr  = addr_q;
  assign src_ready   = (state == S_WAIT);
  assign dev_addr    = addr_q;
  assign dev_wdata   = data_q;
  assign dev_drive   = (state == S_SETUP) || (state == S_PULSE);
  assign dev_e_n     = !((state == S_PULSE) || (state == S_VERIFY));
  assign dev_g_n     = (state != S_VERIFY);
  assign busy        = (state != S_IDLE);
  assign vpp_en      = busy;

  assert_verify_bus_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_g_n |-> (!dev_drive && !dev_e_n));
  assert_supply_in_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_e_n |-> vpp_en);
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_addr)));
  assert_tries_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= N_MAX);
  assert_addr_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_e_n |=> (dev_e_n || ($stable(dev_addr) && $stable(dev_wdata))));
  assert_status_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  assert_range_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(last_q));
endmodule

// File: rtl/burn_sequencer.sv
module burn_sequencer #(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLKS_PER_TICK = 50,
  parameter int TICKS_PER_MS  = 1000,
  parameter int MAX_TRIES     = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] last_addr,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [DATA_W-1:0] src_data,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [DATA_W-1:0] dev_wdata,
  output logic              dev_drive,
  input  logic [DATA_W-1:0] dev_rdata,
  output logic              dev_e_n,
  output logic              dev_g_n,
  output logic              vpp_en,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam int TW = $clog2(3 * MAX_TRIES * TICKS_PER_MS + 1);

  logic          load, fire;
  logic [TW-1:0] load_val;

  fpa_timer #(.CLKS_PER_TICK(CLKS_PER_TICK), .TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .fire(fire)
  );

  fpa_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TICKS_PER_MS(TICKS_PER_MS),
    .MAX_TRIES(MAX_TRIES), .TW(TW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .first_addr(first_addr), .last_addr(last_addr),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .dev_rdata(dev_rdata), .fire(fire), .load(load), .load_val(load_val),
    .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_drive(dev_drive),
    .dev_e_n(dev_e_n), .dev_g_n(dev_g_n), .vpp_en(vpp_en),
    .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr)
  );
endmodule

// File: tb/sim_burn_sequencer.sv
`timescale 1ns/1ps
module sim_burn_sequencer;
  localparam int AW   = 4;
  localparam int CPT  = 2;
  localparam int TPM  = 3;
  localparam int MAXT = 4;
  localparam int NA   = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] first_addr = '0, last_addr = '0;
  logic          fetch_valid, fetch_ready = 1'b0;
  logic [AW-1:0] fetch_addr;
  logic          src_valid = 1'b0, src_ready;
  logic [7:0]    src_data = '0;
  logic [AW-1:0] dev_addr, fail_addr;
  logic [7:0]    dev_wdata, dev_rdata;
  logic          dev_drive, dev_e_n, dev_g_n, vpp_en, busy, done, fail;

  burn_sequencer #(.ADDR_W(AW), .DATA_W(8), .CLKS_PER_TICK(CPT),
                   .TICKS_PER_MS(TPM), .MAX_TRIES(MAXT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .first_addr(first_addr), .last_addr(last_addr),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_drive(dev_drive), .dev_rdata(dev_rdata),
    .dev_e_n(dev_e_n), .dev_g_n(dev_g_n), .vpp_en(vpp_en), .busy(busy),
    .done(done), .fail(fail), .fail_addr(fail_addr));

  int vec = 0, bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int kneed(input int a);
    return (a == 14) ? MAXT + 1 : (a % MAXT) + 1;
  endfunction
  function automatic logic [7:0] srcb(input int a);
    return (a == 2 || a == 8) ? 8'hFF : 8'((a * 37 + 5) & 255);
  endfunction

  int         pc [NA];
  logic [7:0] wr [NA];

  always_comb begin
    if (!dev_e_n && !dev_g_n && !dev_drive && pc[dev_addr] >= kneed(int'(dev_addr)))
      dev_rdata = wr[dev_addr];
    else
      dev_rdata = 8'hFF;
  end

  // port monitor: strobe timing and device model
  initial begin
    int cyc = 0, last_chg = -100, fall_cyc = 0, rise_cyc = -100;
    logic [AW-1:0] p_addr = '0;
    logic [7:0] p_wd = '0;
    logic p_e = 1'b1, p_g = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        if (dev_addr != p_addr || dev_wdata != p_wd) begin
          chk(dev_e_n && (cyc - rise_cyc >= CPT), "R8 addr/data hold after E", cyc - rise_cyc, CPT);
          last_chg = cyc;
        end
        if (p_e && !dev_e_n && dev_g_n) begin
          chk(cyc - last_chg >= CPT, "R8 setup before E", cyc - last_chg, CPT);
          chk(vpp_en && dev_drive, "R3 R11 pulse with supply and data", int'({vpp_en, dev_drive}), 3);
          pc[dev_addr] = pc[dev_addr] + 1;
          wr[dev_addr] = dev_wdata;
          fall_cyc = cyc;
        end
        if (!p_e && dev_e_n && p_g) begin
          int p, k, w;
          p = pc[dev_addr]; k = kneed(int'(dev_addr));
          w = (p <= k) ? TPM * CPT : 3 * k * TPM * CPT;
          if (p <= k) chk(cyc - fall_cyc == w, "R3 initial pulse width", cyc - fall_cyc, w);
          else        chk(cyc - fall_cyc == w, "R6 overprogram pulse width", cyc - fall_cyc, w);
          rise_cyc = cyc;
        end
        if (p_g && !dev_g_n)
          chk((cyc - rise_cyc >= CPT) && !dev_drive && !dev_e_n,
              "R4 R8 verify entry gap and released bus", cyc - rise_cyc, CPT);
      end
      p_addr = dev_addr; p_wd = dev_wdata; p_e = dev_e_n; p_g = dev_g_n;
    end
  end

  // source responder: valid/ready on both channels
  initial begin
    bit pend = 0, hand = 0;
    int paddr = 0, dly = 0, rcyc = 0;
    forever begin
      @(negedge clk);
      if (hand) begin src_valid = 1'b0; hand = 0; end
      if (pend) begin
        if (dly > 0) dly--;
        else if (!src_valid) begin
          src_valid = 1'b1; src_data = srcb(paddr); pend = 0;
        end
      end
      if (src_valid && src_ready && !hand) hand = 1;
      rcyc++;
      if (fetch_valid && (rcyc % 3 != 1) && !pend && !src_valid) begin
        pend = 1; paddr = int'(fetch_addr); dly = rcyc % 3;
        fetch_ready = 1'b1;
      end else begin
        fetch_ready = 1'b0;
      end
    end
  end

  task automatic run(input int f, input int l, input bit poke);
    int t;
    bit stop;
    int ex_fail;
    for (int a = 0; a < NA; a++) begin pc[a] = 0; wr[a] = 8'hFF; end
    first_addr = AW'(f); last_addr = AW'(l);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      first_addr = AW'(13); last_addr = AW'(15); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (!(done || fail) && t < 20000) begin @(negedge clk); t++; end
    chk(t < 20000, "R9 watchdog run completes", t, 20000);
    @(negedge clk);
    stop = 0; ex_fail = -1;
    for (int a = 0; a < NA; a++) begin
      int e;
      e = 0;
      if (!stop && a >= f && a <= l && srcb(a) != 8'hFF) begin
        if (kneed(a) > MAXT) begin e = MAXT; stop = 1; ex_fail = a; end
        else e = kneed(a) + 1;
      end
      if (a < f || a > l)            chk(pc[a] == e, "R9 R12 no pulses outside range", pc[a], e);
      else if (srcb(a) == 8'hFF)     chk(pc[a] == e, "R10 erased byte skipped", pc[a], e);
      else if (ex_fail == a)         chk(pc[a] == e, "R7 pulses up to limit", pc[a], e);
      else                           chk(pc[a] == e, "R5 pulse count per byte", pc[a], e);
      if (e > 0 && ex_fail != a)
        chk(wr[a] == srcb(a), "R3 data presented", int'(wr[a]), int'(srcb(a)));
    end
    if (ex_fail >= 0) begin
      chk(fail && !done, "R7 fail flagged", int'({fail, done}), 2);
      chk(int'(fail_addr) == ex_fail, "R7 fail address", int'(fail_addr), ex_fail);
    end else begin
      chk(done && !fail, "R9 done flagged", int'({done, fail}), 2);
    end
    chk(!vpp_en && !busy && dev_e_n && dev_g_n, "R11 idle after run",
        int'({vpp_en, busy, dev_e_n, dev_g_n}), 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(dev_e_n && dev_g_n && !vpp_en && !busy && !done && !fail && !fetch_valid && !dev_drive,
        "R1 reset state", int'({dev_e_n, dev_g_n, vpp_en, busy, done, fail, fetch_valid, dev_drive}), 192);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(1, 12, 1'b1);
    run(13, 15, 1'b0);
    run(0, 0, 1'b0);
    run(2, 2, 1'b0);
    run(3, 9, 1'b0);
    run(9, 15, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule